// File: doc/BRIEF.md
# Open-Row DRAM Command Sequencer

This block turns a stream of memory read requests into the shortest legal DRAM command sequence for each one. Requests arrive one at a time over a valid/ready handshake and are served strictly in the order they arrive. Each address is split into rank, bank, row and column fields, using one of two field layouts picked by an input pin. The block keeps one open-row record for every rank/bank pair, and the row stays open after a read (open-page policy). From that record it classifies the request as a row hit, a row-empty access or a row conflict.

A hit issues only a READ. An empty bank gets ACTIVATE and then READ. A conflict gets PRECHARGE, ACTIVATE and READ. Programmable counters hold the precharge-to-activate, activate-to-read and read-to-data spacings. The command bus carries one command per cycle and NOP otherwise. Every request closes with a single-cycle data-valid pulse. The pulse carries the decoded rank, bank and column, and the number of commands that request needed, so a user can total the commands over a sequence.

Top module: `dram_seq_top`

## Requirements
- R1: After reset every rank/bank record is empty, `reqReady` is 1, `cmdOut` is NOP and `dataValid` is 0. The first request to any bank therefore takes the empty path.
- R2: With `fieldOrder`=0 the 32-bit address reads, from least significant bit upward: column [15:0], bank [18:16], rank [19], row [31:20].
- R3: With `fieldOrder`=1 the address reads: column [15:0], row [27:16], rank [28], bank [31:29].
- R4: A row hit (the record holds the requested row) issues exactly one command, a READ.
- R5: A row-empty access issues ACTIVATE and then, exactly `tRcd` cycles later, READ.
- R6: A row conflict issues PRECHARGE, then ACTIVATE exactly `tRp` cycles after it, then READ exactly `tRcd` cycles after the ACTIVATE.
- R7: `dataValid` is high for exactly one cycle, `tCas` cycles after the READ. In that cycle `dataRank`, `dataBank` and `dataCol` hold the request's fields, and `dataCmdCount` holds the number of commands the request issued (1, 2 or 3).
- R8: Records are per rank/bank pair. An ACTIVATE or PRECHARGE to one pair leaves every other pair's open row as it was.
- R9: Command codes on `cmdOut` are 0 NOP, 1 ACTIVATE, 2 READ, 3 PRECHARGE. At most one command is driven per cycle. `reqReady` is 0 from the accepting cycle through the data-valid cycle, and it is never 1 while a command is driven.
- R10: Requests complete in arrival order, and a READ leaves its row open. For the five addresses 0x00000010, 0x20000001, 0x40000100, 0x60000010, 0x40000101, the command total is 14 with order 0 and 9 with order 1.
- R11: With a command, `cmdRank` and `cmdBank` name the target pair. `cmdAddr` holds the row (zero-extended) for ACTIVATE, the column for READ, and 0 for PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqAddr | input | 32 | Physical read address |
| fieldOrder | input | 1 | Address layout select (0 or 1) |
| tRp | input | 4 | Precharge-to-activate cycles, at least 1 |
| tRcd | input | 4 | Activate-to-read cycles, at least 1 |
| tCas | input | 4 | Read-to-data cycles, at least 1 |
| cmdOut | output | 2 | Command code |
| cmdRank | output | 1 | Command target rank |
| cmdBank | output | 3 | Command target bank |
| cmdAddr | output | 16 | Row or column for the command |
| dataValid | output | 1 | One-cycle completion pulse |
| dataRank | output | 1 | Completed request rank |
| dataBank | output | 3 | Completed request bank |
| dataCol | output | 16 | Completed request column |
| dataCmdCount | output | 2 | Commands the completed request issued |

## Verification
The scoreboard is fed five kinds of stimulus. The first is a stream in which every request maps to one bank with different rows, so only conflicts follow the first access. The second is the same addresses under the other layout, where they fan out across banks and the last one hits; the two command totals show the layouts apart. The third is interleaved rank/bank pairs that come back to their rows, which shows whether one pair's activation disturbs another. The fourth and fifth run the minimum and maximum delay values, which separate a correct spacing from an off-by-one wait count.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  parameter int ADDR_W = 32;
  parameter int COL_W  = 16;
  parameter int ROW_W  = 12;
  parameter int BANK_W = 3;
  parameter int RANK_W = 1;
  parameter int TIME_W = 4;
  parameter int CNT_W  = 2;

  localparam int KEY_W     = RANK_W + BANK_W;
  localparam int NUM_SLOTS = 1 << KEY_W;
  localparam int CADDR_W   = (COL_W >= ROW_W) ? COL_W : ROW_W;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } fields_t;

  typedef struct packed {
    logic accept;
    logic issuePre;
    logic issueAct;
    logic issueRd;
    logic finish;
  } strobes_t;
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split
  import dram_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              order,
  output fields_t           fields
);
  // layout 0: row | rank | bank | column
  localparam int L0_BANK = COL_W;
  localparam int L0_RANK = L0_BANK + BANK_W;
  localparam int L0_ROW  = L0_RANK + RANK_W;
  // layout 1: bank | rank | row | column
  localparam int L1_ROW  = COL_W;
  localparam int L1_RANK = L1_ROW + ROW_W;
  localparam int L1_BANK = L1_RANK + RANK_W;

  fields_t layout0, layout1;

  always_comb begin
    layout0.col  = addr[0 +: COL_W];
    layout0.bank = addr[L0_BANK +: BANK_W];
    layout0.rank = addr[L0_RANK +: RANK_W];
    layout0.row  = addr[L0_ROW +: ROW_W];
    layout1.col  = addr[0 +: COL_W];
    layout1.row  = addr[L1_ROW +: ROW_W];
    layout1.rank = addr[L1_RANK +: RANK_W];
    layout1.bank = addr[L1_BANK +: BANK_W];
    fields = order ? layout1 : layout0;
  end
endmodule

// File: rtl/dram_seq_datapath.sv
module dram_seq_datapath
  import dram_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobe,
  input  fields_t             reqFields,
  output logic                rowHit,
  output logic                rowEmpty,
  output logic [1:0]          cmdOut,
  output logic [RANK_W-1:0]   cmdRank,
  output logic [BANK_W-1:0]   cmdBank,
  output logic [CADDR_W-1:0]  cmdAddr,
  output logic                dataValid,
  output logic [RANK_W-1:0]   dataRank,
  output logic [BANK_W-1:0]   dataBank,
  output logic [COL_W-1:0]    dataCol,
  output logic [CNT_W-1:0]    dataCmdCount
);
  fields_t           cur;
  logic [CNT_W-1:0]  cmdCnt;
  logic [KEY_W-1:0]  curKey;
  logic [NUM_SLOTS-1:0] openValid;
  logic [ROW_W-1:0]  openRow [NUM_SLOTS];
  logic              anyIssue;

  assign curKey   = {cur.rank, cur.bank};
  assign anyIssue = strobe.issuePre | strobe.issueAct | strobe.issueRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur    <= '0;
      cmdCnt <= '0;
    end else if (strobe.accept) begin
      cur    <= reqFields;
      cmdCnt <= '0;
    end else if (anyIssue) begin
      cmdCnt <= cmdCnt + 1'b1;
    end
  end

  // one open-row record per rank/bank pair
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic             slotValid;
    logic [ROW_W-1:0] slotRow;
    logic             selected;
    assign selected = (curKey == KEY_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid <= 1'b0;
        slotRow   <= '0;
      end else if (selected && strobe.issueAct) begin
        slotValid <= 1'b1;
        slotRow   <= cur.row;
      end else if (selected && strobe.issuePre) begin
        slotValid <= 1'b0;
      end
    end
    assign openValid[g] = slotValid;
    assign openRow[g]   = slotRow;
  end

  assign rowEmpty = !openValid[curKey];
  assign rowHit   = openValid[curKey] && (openRow[curKey] == cur.row);

  always_comb begin
    cmdOut  = CMD_NOP;
    cmdAddr = '0;
    cmdRank = '0;
    cmdBank = '0;
    if (strobe.issuePre) begin
      cmdOut = CMD_PRE;
    end else if (strobe.issueAct) begin
      cmdOut = CMD_ACT;
      cmdAddr[ROW_W-1:0] = cur.row;
    end else if (strobe.issueRd) begin
      cmdOut = CMD_RD;
      cmdAddr[COL_W-1:0] = cur.col;
    end
    if (anyIssue) begin
      cmdRank = cur.rank;
      cmdBank = cur.bank;
    end
  end

  assign dataValid    = strobe.finish;
  assign dataRank     = strobe.finish ? cur.rank : '0;
  assign dataBank     = strobe.finish ? cur.bank : '0;
  assign dataCol      = strobe.finish ? cur.col  : '0;
  assign dataCmdCount = strobe.finish ? cmdCnt   : '0;
endmodule

// File: rtl/dram_seq_control.sv
module dram_seq_control
  import dram_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [TIME_W-1:0] tRp,
  input  logic [TIME_W-1:0] tRcd,
  input  logic [TIME_W-1:0] tCas,
  input  logic              rowHit,
  input  logic              rowEmpty,
  output logic              reqReady,
  output strobes_t          strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_PRE, ST_ACT, ST_RD, ST_WAIT, ST_DONE
  } state_e;

  state_e            state, nextState, waitTarget, nextTarget;
  logic [TIME_W-1:0] waitCnt, loadVal;
  logic              loadWait;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    nextState  = state;
    nextTarget = waitTarget;
    strobe     = '0;
    loadWait   = 1'b0;
    loadVal    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.accept = 1'b1;
          nextState     = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (rowHit)        nextState = ST_RD;
        else if (rowEmpty) nextState = ST_ACT;
        else               nextState = ST_PRE;
      end
      ST_PRE: begin
        strobe.issuePre = 1'b1;
        if (tRp <= 1) nextState = ST_ACT;
        else begin
          nextState = ST_WAIT; nextTarget = ST_ACT;
          loadWait = 1'b1; loadVal = tRp - 1'b1;
        end
      end
      ST_ACT: begin
        strobe.issueAct = 1'b1;
        if (tRcd <= 1) nextState = ST_RD;
        else begin
          nextState = ST_WAIT; nextTarget = ST_RD;
          loadWait = 1'b1; loadVal = tRcd - 1'b1;
        end
      end
      ST_RD: begin
        strobe.issueRd = 1'b1;
        if (tCas <= 1) nextState = ST_DONE;
        else begin
          nextState = ST_WAIT; nextTarget = ST_DONE;
          loadWait = 1'b1; loadVal = tCas - 1'b1;
        end
      end
      ST_WAIT: begin
        if (waitCnt <= 1) nextState = waitTarget;
      end
      ST_DONE: begin
        strobe.finish = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      waitCnt    <= '0;
      waitTarget <= ST_IDLE;
    end else begin
      state      <= nextState;
      waitTarget <= nextTarget;
      if (loadWait)              waitCnt <= loadVal;
      else if (state == ST_WAIT) waitCnt <= waitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top
  import dram_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                fieldOrder,
  input  logic [TIME_W-1:0]   tRp,
  input  logic [TIME_W-1:0]   tRcd,
  input  logic [TIME_W-1:0]   tCas,
  output logic [1:0]          cmdOut,
  output logic [RANK_W-1:0]   cmdRank,
  output logic [BANK_W-1:0]   cmdBank,
  output logic [CADDR_W-1:0]  cmdAddr,
  output logic                dataValid,
  output logic [RANK_W-1:0]   dataRank,
  output logic [BANK_W-1:0]   dataBank,
  output logic [COL_W-1:0]    dataCol,
  output logic [CNT_W-1:0]    dataCmdCount
);
  fields_t  reqFields;
  strobes_t strobe;
  logic     rowHit, rowEmpty;

  dram_addr_split uSplit (
    .addr   (reqAddr),
    .order  (fieldOrder),
    .fields (reqFields)
  );

  dram_seq_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .tRp      (tRp),
    .tRcd     (tRcd),
    .tCas     (tCas),
    .rowHit   (rowHit),
    .rowEmpty (rowEmpty),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  dram_seq_datapath uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqFields    (reqFields),
    .rowHit       (rowHit),
    .rowEmpty     (rowEmpty),
    .cmdOut       (cmdOut),
    .cmdRank      (cmdRank),
    .cmdBank      (cmdBank),
    .cmdAddr      (cmdAddr),
    .dataValid    (dataValid),
    .dataRank     (dataRank),
    .dataBank     (dataBank),
    .dataCol      (dataCol),
    .dataCmdCount (dataCmdCount)
  );
endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker
  import dram_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [1:0]        cmdOut,
  input logic              dataValid,
  input logic [TIME_W-1:0] tRp,
  input logic [TIME_W-1:0] tRcd,
  input logic [TIME_W-1:0] tCas
);
  logic [1:0]        lastCmd;
  logic [TIME_W:0]   gap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastCmd <= CMD_NOP;
      gap     <= '0;
    end else if (cmdOut != CMD_NOP) begin
      lastCmd <= cmdOut;
      gap     <= 1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  assert_act_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_ACT && lastCmd == CMD_PRE) |-> (gap == {1'b0, tRp}));

  assert_rd_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_RD && lastCmd == CMD_ACT) |-> (gap == {1'b0, tRcd}));

  assert_data_delay_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> (lastCmd == CMD_RD && gap == {1'b0, tCas}));

  assert_data_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut != CMD_NOP || dataValid) |-> !reqReady);
endmodule

bind dram_seq_top dram_seq_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .cmdOut    (cmdOut),
  .dataValid (dataValid),
  .tRp       (tRp),
  .tRcd      (tRcd),
  .tCas      (tCas)
);

// File: tb/sim_dram_seq_top.sv
module sim_dram_seq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        reqValid = 1'b0, reqReady, fieldOrder = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  tRp = 4'd2, tRcd = 4'd2, tCas = 4'd2;
  logic [1:0]  cmdOut, dataCmdCount;
  logic        cmdRank, dataValid, dataRank;
  logic [2:0]  cmdBank, dataBank;
  logic [15:0] cmdAddr, dataCol;

  dram_seq_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .fieldOrder(fieldOrder), .tRp(tRp), .tRcd(tRcd),
    .tCas(tCas), .cmdOut(cmdOut), .cmdRank(cmdRank), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .dataValid(dataValid), .dataRank(dataRank),
    .dataBank(dataBank), .dataCol(dataCol), .dataCmdCount(dataCmdCount)
  );

  typedef struct {
    logic [1:0] cmd; logic rank; logic [2:0] bank; logic [15:0] addr;
    int gap; string req;
  } cmdItem_t;
  typedef struct {
    logic rank; logic [2:0] bank; logic [15:0] col; logic [1:0] cnt; string req;
  } dataItem_t;

  cmdItem_t  cmdQ[$];
  dataItem_t dataQ[$];
  int nTests = 0, nFails = 0;
  int cyc = 0, lastCmdCyc = 0, rdCyc = 0, totalCmds = 0, sumCnt = 0;
  bit        mOpen [16];
  logic [11:0] mRow [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares bus activity with the scoreboard queues
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (cmdOut != 2'd0) begin
        totalCmds++;
        chk(reqReady == 1'b0, "R9", "ready during command", reqReady, 0);
        if (cmdQ.size() == 0) chk(0, "R10", "unexpected command", cmdOut, 0);
        else begin
          cmdItem_t e;
          e = cmdQ.pop_front();
          chk(cmdOut == e.cmd, e.req, "command code", cmdOut, e.cmd);
          chk(cmdRank == e.rank && cmdBank == e.bank, "R11", "command target",
              {cmdRank, cmdBank}, {e.rank, e.bank});
          chk(cmdAddr == e.addr, "R11", "command address", cmdAddr, e.addr);
          if (e.gap != 0)
            chk(cyc - lastCmdCyc == e.gap, e.req, "command spacing",
                cyc - lastCmdCyc, e.gap);
        end
        lastCmdCyc = cyc;
        if (cmdOut == 2'd2) rdCyc = cyc;
      end
      if (dataValid) begin
        chk(reqReady == 1'b0, "R9", "ready at data pulse", reqReady, 0);
        chk(cyc - rdCyc == int'(tCas), "R7", "read to data delay", cyc - rdCyc, tCas);
        sumCnt += dataCmdCount;
        if (dataQ.size() == 0) chk(0, "R10", "unexpected data", dataCol, 0);
        else begin
          dataItem_t d;
          d = dataQ.pop_front();
          chk(dataRank == d.rank && dataBank == d.bank, "R7", "data target",
              {dataRank, dataBank}, {d.rank, d.bank});
          chk(dataCol == d.col, "R7", "data column", dataCol, d.col);
          chk(dataCmdCount == d.cnt, d.req, "command count", dataCmdCount, d.cnt);
        end
      end
    end
  end

  // driver: predicts commands from the requirement model, then hands over
  task automatic sendReq(input logic [31:0] a);
    logic rk; logic [2:0] bk; logic [11:0] rw; logic [15:0] cl;
    int key; cmdItem_t c; dataItem_t d; string tag;
    cl = a[15:0];
    if (!fieldOrder) begin rw = a[31:20]; rk = a[19]; bk = a[18:16]; end  // R2
    else begin bk = a[31:29]; rk = a[28]; rw = a[27:16]; end              // R3
    key = {rk, bk};
    c.rank = rk; c.bank = bk;
    if (mOpen[key] && mRow[key] == rw) begin
      tag = "R4"; d.cnt = 2'd1;
      c.cmd = 2'd2; c.addr = cl; c.gap = 0; c.req = tag; cmdQ.push_back(c);
    end else begin
      if (mOpen[key]) begin
        tag = "R6"; d.cnt = 2'd3;
        c.cmd = 2'd3; c.addr = 16'd0; c.gap = 0; c.req = tag; cmdQ.push_back(c);
        c.cmd = 2'd1; c.addr = {4'd0, rw}; c.gap = tRp; cmdQ.push_back(c);
      end else begin
        tag = "R5"; d.cnt = 2'd2;
        c.cmd = 2'd1; c.addr = {4'd0, rw}; c.gap = 0; c.req = tag; cmdQ.push_back(c);
      end
      c.cmd = 2'd2; c.addr = cl; c.gap = tRcd; c.req = tag; cmdQ.push_back(c);
      mOpen[key] = 1'b1; mRow[key] = rw;
    end
    d.rank = rk; d.bank = bk; d.col = cl; d.req = tag;
    dataQ.push_back(d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R9", "ready after accept", reqReady, 0);
  endtask

  task automatic drain();
    int t = 0;
    while ((cmdQ.size() != 0 || dataQ.size() != 0 || !reqReady) && t < 2000) begin
      @(negedge clk); t++;
    end
    chk(t < 2000, "R10", "queues drained", cmdQ.size() + dataQ.size(), 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    for (int i = 0; i < 16; i++) begin mOpen[i] = 1'b0; mRow[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    chk(cmdOut == 2'd0, "R1", "command after reset", cmdOut, 0);
    chk(dataValid == 1'b0, "R1", "data after reset", dataValid, 0);
    totalCmds = 0; sumCnt = 0;
  endtask

  initial begin
    // watchdog
    repeat (150000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    // five-request stream, layout 0: one bank, changing rows (R2, R10)
    fieldOrder = 1'b0; tRp = 4'd2; tRcd = 4'd3; tCas = 4'd4;
    doReset();
    sendReq(32'h00000010); sendReq(32'h20000001); sendReq(32'h40000100);
    sendReq(32'h60000010); sendReq(32'h40000101);
    drain();
    chk(totalCmds == 14, "R10", "order 0 total", totalCmds, 14);
    chk(sumCnt == 14, "R10", "order 0 count sum", sumCnt, 14);

    // same stream, layout 1: spread across banks, last one hits (R3, R1)
    fieldOrder = 1'b1; tRp = 4'd3; tRcd = 4'd2; tCas = 4'd5;
    doReset();
    sendReq(32'h00000010); sendReq(32'h20000001); sendReq(32'h40000100);
    sendReq(32'h60000010); sendReq(32'h40000101);
    drain();
    chk(totalCmds == 9, "R10", "order 1 total", totalCmds, 9);
    chk(sumCnt == 9, "R10", "order 1 count sum", sumCnt, 9);

    // independent pairs with minimum delays (R8, R4)
    fieldOrder = 1'b0; tRp = 4'd1; tRcd = 4'd1; tCas = 4'd1;
    doReset();
    sendReq(32'h00510012);   // rank0 bank1 row5
    sendReq(32'h00720013);   // rank0 bank2 row7
    sendReq(32'h00990014);   // rank1 bank1 row9
    sendReq(32'h00510034);   // rank0 bank1 row5 -> hit
    sendReq(32'h00990035);   // rank1 bank1 row9 -> hit
    sendReq(32'h00820036);   // rank0 bank2 row8 -> conflict
    drain();
    chk(totalCmds == 11, "R8", "pair total", totalCmds, 11);

    // conflict with maximum delays, layout 1 (R6, R7)
    fieldOrder = 1'b1; tRp = 4'd15; tRcd = 4'd15; tCas = 4'd15;
    doReset();
    sendReq(32'hC001ABCD);   // bank6 row1
    sendReq(32'hC0021234);   // bank6 row2 -> conflict
    sendReq(32'hD0021234);   // bank6 rank1 row2 -> empty
    drain();
    chk(totalCmds == 7, "R6", "long delay total", totalCmds, 7);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule